// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit timer counter that advances once every N+1 qualified ticks, where N is a programmable prescale value. A separate `tick_i` input qualifies each advance, so the timer can run on every clock or be driven by an external edge detector. Four match channels compare their values against the timer counter. Each channel can be set up on its own to raise an interrupt flag, to return the timer to zero, or to halt counting.

Software reaches all state through a flat register port. The port has a single-cycle write strobe and a combinational read mux. Pending match flags appear as a vector and as one combined interrupt line, and software clears them by writing ones.

Register map (word address on `addr_i`):

| Address | Register | Bits |
|---|---|---|
| 0 | match flags | write-one-to-clear |
| 1 | control | bit 0 run, bit 1 hold-in-reset |
| 2 | prescale value | |
| 3 | prescale count | |
| 4 | timer count | |
| 5 | match control | for channel n: bit 3n irq, bit 3n+1 reset, bit 3n+2 stop |
| 8+n | match value of channel n | |

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset every register reads zero, and `irq_pending_o` and `irq_o` are low.
- R2: With control bit 0 set and `tick_i` high, the prescale count steps 0..P, where P is the prescale value (address 2). On the tick after it reaches P it returns to 0 and the timer count (address 4) increments, so the timer advances once every P+1 ticks.
- R3: When control bit 0 is clear, or `tick_i` is low, both the prescale count and the timer count hold their values.
- R4: While control bit 1 is set, both counts become zero on the next clock edge and stay zero, whatever bit 0 and `tick_i` are.
- R5: The timer count wraps from 0xFFFFFFFF to 0, and the wrap alone sets no flag.
- R6: When a count step loads the timer with a value equal to the match value of channel n, and match-control bit 3n is set, flag bit n (address 0, bits 3:0) is set on that same edge. `irq_o` is high whenever any flag is set.
- R7: If match-control bit 3n+1 is set and the timer equals the match value of channel n, the next count step loads zero instead of incrementing.
- R8: If match-control bit 3n+2 is set, control bit 0 clears on the edge on which a count step loads the match value of channel n, so both counts stop there.
- R9: Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the flag ends up set.
- R10: Every register in the map reads back the value last written. A software write to either count takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-advance qualifier |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_pending_o | output | 4 | Pending match flags |
| irq_o | output | 1 | OR of all pending flags |

## Verification
A prescale count stuck at or skipping past its limit shows up at the timer-count readback within P+1 ticks, as a count that is too low or too high. A wrong reset-or-stop decode changes the timer count on the very next count step after a match: it fails to drop to zero, or it keeps moving after it should have halted, and a read at the next negative clock edge sees this. Flag faults show on `irq_o` on the same edge the match value is loaded, and the checker also catches any flag that falls without a clearing write.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_PSCL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_PCNT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TCNT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;

  typedef struct packed {
    logic hold;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] pc_o,
  output logic             step_o
);
  logic [CNT_W-1:0] pc_q;
  logic             at_limit;

  assign at_limit = (pc_q == limit_i);
  assign step_o   = adv_i & at_limit;
  assign pc_o     = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (clr_i)    pc_q <= '0;
    else if (wr_i)     pc_q <= wdata_i;
    else if (adv_i)    pc_q <= at_limit ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/timer_match_unit.sv
module timer_match_unit #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4,
  localparam int unsigned MCTL_W   = 3 * NUM_MATCH
) (
  input  logic [CNT_W-1:0]                 tc_i,
  input  logic [CNT_W-1:0]                 tc_inc_i,
  input  logic                             step_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]  match_i,
  input  logic [MCTL_W-1:0]                mctl_i,
  output logic                             rst_req_o,
  output logic                             stop_req_o,
  output logic [NUM_MATCH-1:0]             set_o
);
  logic [NUM_MATCH-1:0] rst_ch, stop_ch, hit_now, hit_next;
  logic [CNT_W-1:0]     load_val;

  // value the timer takes if a step occurs this cycle
  assign load_val = rst_req_o ? '0 : tc_inc_i;

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_ch
    assign hit_now[n]  = (tc_i == match_i[n]);
    assign hit_next[n] = (load_val == match_i[n]);
    assign rst_ch[n]   = hit_now[n] & mctl_i[3*n+1];
    assign set_o[n]    = step_i & hit_next[n] & mctl_i[3*n];
    assign stop_ch[n]  = step_i & hit_next[n] & mctl_i[3*n+2];
  end

  assign rst_req_o  = |rst_ch;
  assign stop_req_o = |stop_ch;
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int unsigned NUM_MATCH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_en_i,
  input  logic [NUM_MATCH-1:0] clr_mask_i,
  input  logic [NUM_MATCH-1:0] set_i,
  output logic [NUM_MATCH-1:0] flags_o
);
  logic [NUM_MATCH-1:0] flags_q, clr;

  assign clr     = clr_en_i ? clr_mask_i : '0;
  assign flags_o = flags_q;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr) | set_i;
  end
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4,
  localparam int unsigned MCTL_W   = 3 * NUM_MATCH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [CNT_W-1:0]     rdata_o,
  output logic [NUM_MATCH-1:0] irq_pending_o,
  output logic                 irq_o
);
  ctrl_t                          ctrl_q;
  logic [CNT_W-1:0]               pr_q, tc_q, pc;
  logic [MCTL_W-1:0]              mctl_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic                           adv, step, step_eff, rst_req, stop_req;
  logic                           wr_ctrl, wr_pr, wr_pc, wr_tc, wr_mctl, wr_flags;
  logic [NUM_MATCH-1:0]           set_vec;

  assign wr_flags = wr_en_i & (addr_i == A_FLAGS);
  assign wr_ctrl  = wr_en_i & (addr_i == A_CTRL);
  assign wr_pr    = wr_en_i & (addr_i == A_PSCL);
  assign wr_pc    = wr_en_i & (addr_i == A_PCNT);
  assign wr_tc    = wr_en_i & (addr_i == A_TCNT);
  assign wr_mctl  = wr_en_i & (addr_i == A_MCTL);

  assign adv      = ctrl_q.run & ~ctrl_q.hold & tick_i;
  assign step_eff = step & ~wr_tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_ctrl)  ctrl_q <= ctrl_t'(wdata_i[1:0]);
    else if (stop_req) ctrl_q.run <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q   <= '0;
      mctl_q <= '0;
    end else begin
      if (wr_pr)   pr_q   <= wdata_i;
      if (wr_mctl) mctl_q <= wdata_i[MCTL_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_mreg
    localparam logic [ADDR_W-1:0] MY_ADDR = A_MATCH0 + ADDR_W'(n);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            match_q[n] <= '0;
      else if (wr_en_i && addr_i == MY_ADDR)  match_q[n] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tc_q <= '0;
    else if (ctrl_q.hold) tc_q <= '0;
    else if (wr_tc)       tc_q <= wdata_i;
    else if (step)        tc_q <= rst_req ? '0 : tc_q + 1'b1;
  end

  timer_prescaler #(.CNT_W(CNT_W)) i_pscl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctrl_q.hold),
    .adv_i   (adv),
    .wr_i    (wr_pc),
    .wdata_i (wdata_i),
    .limit_i (pr_q),
    .pc_o    (pc),
    .step_o  (step)
  );

  timer_match_unit #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) i_match (
    .tc_i       (tc_q),
    .tc_inc_i   (tc_q + 1'b1),
    .step_i     (step_eff),
    .match_i    (match_q),
    .mctl_i     (mctl_q),
    .rst_req_o  (rst_req),
    .stop_req_o (stop_req),
    .set_o      (set_vec)
  );

  timer_irq_flags #(.NUM_MATCH(NUM_MATCH)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (wr_flags),
    .clr_mask_i (wdata_i[NUM_MATCH-1:0]),
    .set_i      (set_vec),
    .flags_o    (irq_pending_o)
  );

  assign irq_o = |irq_pending_o;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_FLAGS: rdata_o = CNT_W'(irq_pending_o);
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_PSCL:  rdata_o = pr_q;
      A_PCNT:  rdata_o = pc;
      A_TCNT:  rdata_o = tc_q;
      A_MCTL:  rdata_o = CNT_W'(mctl_q);
      default: begin
        for (int n = 0; n < NUM_MATCH; n++)
          if (addr_i == A_MATCH0 + ADDR_W'(n)) rdata_o = match_q[n];
      end
    endcase
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 run_q,
  input logic                 hold_q,
  input logic [CNT_W-1:0]     tc_q,
  input logic [CNT_W-1:0]     pc_q,
  input logic                 step_eff,
  input logic                 rst_req,
  input logic                 stop_req,
  input logic [NUM_MATCH-1:0] flags
);
  logic wr_cnt, wr_ctl, wr_flg;
  assign wr_cnt = wr_en_i && (addr_i == A_PCNT || addr_i == A_TCNT);
  assign wr_ctl = wr_en_i && (addr_i == A_CTRL);
  assign wr_flg = wr_en_i && (addr_i == A_FLAGS);

  p_tc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_eff && !hold_q && !rst_req) |=> (tc_q == $past(tc_q) + 1'b1));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !hold_q && !wr_cnt) |=> ($stable(tc_q) && $stable(pc_q)));

  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |=> (tc_q == '0 && pc_q == '0));

  p_match_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_eff && rst_req && !hold_q) |=> (tc_q == '0));

  p_stop_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req && !wr_ctl) |=> !run_q);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flg |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind prescaled_match_timer timer_checker #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .run_q    (ctrl_q.run),
  .hold_q   (ctrl_q.hold),
  .tc_q     (tc_q),
  .pc_q     (pc),
  .step_eff (step_eff),
  .rst_req  (rst_req),
  .stop_req (stop_req),
  .flags    (irq_pending_o)
);

// File: tb/test_prescaled_match_timer.sv
module test_prescaled_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  localparam logic [3:0] A_FLG = 4'd0, A_CTL = 4'd1, A_PR = 4'd2, A_PC = 4'd3,
                         A_TC = 4'd4, A_MC = 4'd5, A_M0 = 4'd8, A_M1 = 4'd9,
                         A_M2 = 4'd10, A_M3 = 4'd11;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VECS [NV] = '{
    // R2 prescale of 2: 7 ticks -> pc 1, tc 2
    '{OP_WR, A_PR, 32'd2, 4'd2}, '{OP_WR, A_CTL, 32'd1, 4'd2}, '{OP_TK, 4'd0, 32'd7, 4'd2},
    '{OP_RD, A_PC, 32'd1, 4'd2}, '{OP_RD, A_TC, 32'd2, 4'd2},
    // R3 disabled: counts frozen
    '{OP_WR, A_CTL, 32'd0, 4'd3}, '{OP_TK, 4'd0, 32'd5, 4'd3},
    '{OP_RD, A_TC, 32'd2, 4'd3}, '{OP_RD, A_PC, 32'd1, 4'd3},
    // R4 hold-in-reset with run set
    '{OP_WR, A_CTL, 32'd3, 4'd4}, '{OP_TK, 4'd0, 32'd3, 4'd4},
    '{OP_RD, A_TC, 32'd0, 4'd4}, '{OP_RD, A_PC, 32'd0, 4'd4},
    // R2 prescale of 0: every tick
    '{OP_WR, A_PR, 32'd0, 4'd2}, '{OP_WR, A_CTL, 32'd1, 4'd2}, '{OP_TK, 4'd0, 32'd4, 4'd2},
    '{OP_RD, A_TC, 32'd4, 4'd2},
    // R6 channel 1 interrupt at 6
    '{OP_WR, A_M1, 32'd6, 4'd6}, '{OP_WR, A_MC, 32'h8, 4'd6}, '{OP_TK, 4'd0, 32'd2, 4'd6},
    '{OP_RD, A_FLG, 32'h2, 4'd6},
    // R9 write zero keeps, write one clears
    '{OP_WR, A_FLG, 32'h0, 4'd9}, '{OP_RD, A_FLG, 32'h2, 4'd9},
    '{OP_WR, A_FLG, 32'h2, 4'd9}, '{OP_RD, A_FLG, 32'h0, 4'd9},
    // R7 channel 0 reset at 3: 1,2,3,0,1
    '{OP_WR, A_CTL, 32'd0, 4'd7}, '{OP_WR, A_TC, 32'd0, 4'd7}, '{OP_WR, A_M0, 32'd3, 4'd7},
    '{OP_WR, A_MC, 32'h2, 4'd7}, '{OP_WR, A_CTL, 32'd1, 4'd7}, '{OP_TK, 4'd0, 32'd5, 4'd7},
    '{OP_RD, A_TC, 32'd1, 4'd7}, '{OP_RD, A_FLG, 32'h0, 4'd7},
    // R8 channel 2 stop at 4
    '{OP_WR, A_CTL, 32'd0, 4'd8}, '{OP_WR, A_TC, 32'd0, 4'd8}, '{OP_WR, A_M2, 32'd4, 4'd8},
    '{OP_WR, A_MC, 32'h100, 4'd8}, '{OP_WR, A_CTL, 32'd1, 4'd8}, '{OP_TK, 4'd0, 32'd9, 4'd8},
    '{OP_RD, A_TC, 32'd4, 4'd8}, '{OP_RD, A_CTL, 32'd0, 4'd8},
    // R5 wrap without flag
    '{OP_WR, A_MC, 32'h0, 4'd5}, '{OP_WR, A_TC, 32'hFFFF_FFFE, 4'd5}, '{OP_WR, A_CTL, 32'd1, 4'd5},
    '{OP_TK, 4'd0, 32'd3, 4'd5}, '{OP_RD, A_TC, 32'd1, 4'd5}, '{OP_RD, A_FLG, 32'h0, 4'd5},
    // R10 readback
    '{OP_WR, A_M3, 32'hA5A5_1234, 4'd10}, '{OP_RD, A_M3, 32'hA5A5_1234, 4'd10},
    '{OP_WR, A_PR, 32'h55, 4'd10}, '{OP_RD, A_PR, 32'h55, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq_pend;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_match_timer i_prescaled_match_timer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .wr_en_i       (wr_en),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .irq_pending_o (irq_pend),
    .irq_o         (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a negative edge
  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      if (a == 6 || a == 7) continue;
      do_rd(4'(a), 32'd0, "R1");
    end
    check("R1 irq_pending_o", 32'(irq_pend), 32'd0);
    check("R1 irq_o", 32'(irq), 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR: do_wr(VECS[i].addr, VECS[i].data);
        OP_TK: do_ticks(int'(VECS[i].data));
        default: do_rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec%0d", VECS[i].req, i));
      endcase
    end

    // R9 set wins over same-cycle clear; R6 irq_o follows
    do_wr(A_CTL, 32'd0);
    do_wr(A_TC, 32'd0);
    do_wr(A_PR, 32'd0);
    do_wr(A_M0, 32'd1);
    do_wr(A_MC, 32'h1);
    do_wr(A_FLG, 32'hF);
    do_wr(A_CTL, 32'd1);
    tick = 1'b1; wr_en = 1'b1; addr = A_FLG; wdata = 32'h1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    do_rd(A_FLG, 32'h1, "R9 set beats clear");
    check("R6 irq_o", 32'(irq), 32'd1);

    // R10 software count write beats a count step
    tick = 1'b1; wr_en = 1'b1; addr = A_TC; wdata = 32'd100;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    do_rd(A_TC, 32'd100, "R10 write beats step");

    // R3 tick low with run set: frozen
    repeat (4) @(negedge clk);
    do_rd(A_TC, 32'd100, "R3 tick low");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule